// File: doc/BRIEF.md
# Clock Synthesizer Configuration Register Slave

This block is the two-wire serial slave that holds the configuration of a video clock synthesizer. A bus master writes and reads bytes by word address. The block drives the synthesizer's control fields from its registers and reports the PLL lock state. SCL and SDA come in as plain levels. The block brings them into the system clock through a synchronizer chain and finds START, STOP and bit edges from their transitions. The open-drain SDA pad is modelled as an output-enable, where 1 pulls the line low.

The loop-critical settings are the charge-pump current, the VCO divider, the 12-bit feedback divider and the input-conditioning bypass. Writes to these land in shadow registers, and the synthesizer keeps running on its old settings. A single commit write copies every shadow into the live set in the same cycle, so the loop never sees a half-updated divider. The input-control register and the output-enable register act on the write itself. Multi-byte writes and sequential reads advance the word address, and the address wraps inside its 16-byte page.

Top module: `clksyn_cfg_slave`

## Requirements
- R1: The slave answers the 7-bit address 010011x, where x is the level of `addrSel`, and sends an ACK only for that address. For any other address it leaves SDA released for the rest of the transfer.
- R2: After reset, address 00h reads 01h (`cpAlways`=1 and every other input-control output 0), 05h bit 0 is 1 (`schmittBypass`=1), `outEnable` is 0, the pump current, VCO divider and feedback divider are 0, and SDA is released.
- R3: A write to 00h acts at once. Bits 0,1,2,3,4,6 drive `cpAlways`, `coastPol`, `hsyncFall`, `fbkFall`, `fbkExt` and `lockPinEn`. A write to 06h acts at once through bit 1 (`outEnable`). Unimplemented bits of both read as 0.
- R4: Writes to 01h (bits 2:0 pump current, 5:4 VCO divider), 02h, 03h (bits 3:0) and 05h (bit 0) change only shadow copies. The active outputs keep their values.
- R5: Writing 5Ah to 08h copies all four shadows into the active outputs at once. Any other value written to 08h changes nothing.
- R6: Reading 01h, 02h, 03h or 05h returns the shadow value, even while it differs from the active value.
- R7: The active feedback divider `fbDiv` is {03h[3:0], 02h} as last committed.
- R8: Every data byte moves the word address to the next address. The low 4 bits wrap from F to 0 and the upper bits stay the same, for both writes and reads.
- R9: 11h reads 01h. 12h reads the synchronized `pllLocked` level in bit 1 and 0 in every other bit.
- R10: Reads of 04h, 07h, 08h, 10h and any other unimplemented address return 00h. Writes to them change no output and no readable register, and every data byte of a write is ACKed.
- R11: A repeated START restarts address reception, so a write of the word address followed by a repeated START and a read returns data from that address.
- R12: During reads the slave changes SDA only while SCL is low. An ACK from the master fetches the next byte, and a NACK ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock level from the pad |
| sdaIn | input | 1 | Serial data level from the pad |
| sdaOe | output | 1 | 1 pulls SDA low |
| addrSel | input | 1 | Selects the low bit of the slave address |
| pllLocked | input | 1 | Live PLL lock status |
| cpAlways | output | 1 | Charge pump always on (0 = gated by vertical sync) |
| coastPol | output | 1 | Level of vertical sync that disables the pump |
| hsyncFall | output | 1 | Lock to the falling edge of horizontal sync |
| fbkFall | output | 1 | Lock to the falling edge of external feedback |
| fbkExt | output | 1 | Use the external feedback divider |
| lockPinEn | output | 1 | Enable the lock status pin |
| pumpCur | output | 3 | Active charge-pump current code |
| vcoDiv | output | 2 | Active VCO post-divider code |
| fbDiv | output | 12 | Active feedback divider word |
| schmittBypass | output | 1 | Active bypass of input conditioning |
| outEnable | output | 1 | Clock and sync outputs enabled |

## Verification
On every cycle the assertions check these properties: SDA stays still while SCL is high outside START and STOP, each complete write byte and each matching address is ACKed, a wrong address leaves the bus released, shadowed writes leave the active fields alone, a commit copies the shadows exactly, and the word address keeps its page. Only the bench scenarios can show the values themselves. These are the reset contents, the bit mapping of each register, shadow readback, the rejected commit code, page wrap on reads and writes, the live lock bit and the repeated-START read path.

// File: rtl/clksyn_cfg_pkg.sv
package clksyn_cfg_pkg;
  typedef struct packed {
    logic       loadPtr;
    logic       wrEn;
    logic       incPtr;
    logic [7:0] data;
  } busStrobe_t;

  typedef struct packed {
    logic        cpAlways;
    logic        coastPol;
    logic        hsyncFall;
    logic        fbkFall;
    logic        fbkExt;
    logic        lockPinEn;
    logic [2:0]  pumpCur;
    logic [1:0]  vcoDiv;
    logic [11:0] fbDiv;
    logic        schmittBypass;
    logic        outEnable;
  } cfgOut_t;

  localparam logic [7:0] A_INCTRL = 8'h00;
  localparam logic [7:0] A_LOOP   = 8'h01;
  localparam logic [7:0] A_FBLO   = 8'h02;
  localparam logic [7:0] A_FBHI   = 8'h03;
  localparam logic [7:0] A_TRIG   = 8'h05;
  localparam logic [7:0] A_OUTEN  = 8'h06;
  localparam logic [7:0] A_COMMIT = 8'h08;
  localparam logic [7:0] A_REV    = 8'h11;
  localparam logic [7:0] A_STAT   = 8'h12;
endpackage

// File: rtl/clksyn_cfg_ctl.sv
module clksyn_cfg_ctl
  import clksyn_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] DEV_PREFIX  = 6'b010011
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrSel,
  input  logic [7:0] rdData,
  output busStrobe_t strb,
  output logic       sdaOe
);
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEVACK, S_WADDR, S_WADDRACK,
    S_WDATA, S_WDACK, S_RDATA, S_RDACK
  } busState_t;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclSync, sdaSync, sclPrev, sdaPrev;
  logic sclRise, sclFall, startSeen, stopSeen;
  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic isRead, mAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign sclSync   = sclPipe[SYNC_STAGES-1];
  assign sdaSync   = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclSync & ~sclPrev;
  assign sclFall   = ~sclSync & sclPrev;
  assign startSeen = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopSeen  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      isRead  <= 1'b0;
      mAck    <= 1'b0;
      sdaOe   <= 1'b0;
      strb    <= '0;
    end else begin
      strb <= '0;
      if (startSeen) begin
        state  <= S_DEV;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopSeen) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else if (sclRise) begin
        case (state)
          S_DEV, S_WADDR, S_WDATA: begin
            rxShift <= {rxShift[6:0], sdaSync};
            bitCnt  <= bitCnt + 4'd1;
          end
          S_RDACK: mAck <= ~sdaSync;
          default: ;
        endcase
      end else if (sclFall) begin
        case (state)
          S_DEV: if (bitCnt == 4'd8) begin
            if (rxShift[7:1] == {DEV_PREFIX, addrSel}) begin
              sdaOe  <= 1'b1;
              isRead <= rxShift[0];
              state  <= S_DEVACK;
            end else begin
              state <= S_IDLE;
            end
          end
          S_WADDR: if (bitCnt == 4'd8) begin
            sdaOe        <= 1'b1;
            strb.loadPtr <= 1'b1;
            strb.data    <= rxShift;
            state        <= S_WADDRACK;
          end
          S_WDATA: if (bitCnt == 4'd8) begin
            sdaOe     <= 1'b1;
            strb.wrEn <= 1'b1;
            strb.data <= rxShift;
            state     <= S_WDACK;
          end
          S_DEVACK: begin
            if (isRead) begin
              txShift <= rdData;
              sdaOe   <= ~rdData[7];
              bitCnt  <= 4'd1;
              state   <= S_RDATA;
            end else begin
              sdaOe  <= 1'b0;
              bitCnt <= '0;
              state  <= S_WADDR;
            end
          end
          S_WADDRACK, S_WDACK: begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            state  <= S_WDATA;
          end
          S_RDATA: begin
            if (bitCnt == 4'd8) begin
              sdaOe       <= 1'b0;
              strb.incPtr <= 1'b1;
              state       <= S_RDACK;
            end else begin
              txShift <= {txShift[6:0], 1'b0};
              sdaOe   <= ~txShift[6];
              bitCnt  <= bitCnt + 4'd1;
            end
          end
          S_RDACK: begin
            if (mAck) begin
              txShift <= rdData;
              sdaOe   <= ~rdData[7];
              bitCnt  <= 4'd1;
              state   <= S_RDATA;
            end else begin
              state <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R12: SDA is only moved while SCL is low
  p_sda_steady_r12: assert property (@(posedge clk) disable iff (!rstN)
    (sclSync && sclPrev) |-> $stable(sdaOe));

  // R10: every complete write data byte is acknowledged
  p_data_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WDATA && bitCnt == 4'd8 && sclFall) |=> sdaOe);

  // R1: a foreign address leaves the bus released
  p_nack_foreign_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEV && bitCnt == 4'd8 && sclFall &&
     rxShift[7:1] != {DEV_PREFIX, addrSel}) |=> !sdaOe);

  // R1: a matching address is acknowledged
  p_ack_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEV && bitCnt == 4'd8 && sclFall &&
     rxShift[7:1] == {DEV_PREFIX, addrSel}) |=> sdaOe);
endmodule

// File: rtl/clksyn_cfg_regs.sv
module clksyn_cfg_regs
  import clksyn_cfg_pkg::*;
#(
  parameter int         PAGE_BITS   = 4,
  parameter logic [7:0] COMMIT_CODE = 8'h5A,
  parameter logic [7:0] REV_CODE    = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  busStrobe_t strb,
  input  logic       pllLocked,
  output logic [7:0] rdData,
  output cfgOut_t    cfg
);
  localparam logic [PAGE_BITS-1:0] PAGE_ONE = PAGE_BITS'(1);

  logic [7:0]  ptr;
  logic [7:0]  ctrlReg;
  logic        oeReg;
  logic [7:0]  loopSh, fbLoSh;
  logic [3:0]  fbHiSh;
  logic        trigSh;
  logic [7:0]  loopAct;
  logic [11:0] fbAct;
  logic        trigAct;
  logic [1:0]  lockPipe;
  logic        commitNow;

  assign commitNow = strb.wrEn && ptr == A_COMMIT && strb.data == COMMIT_CODE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockPipe <= '0;
    else       lockPipe <= {lockPipe[0], pllLocked};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr     <= '0;
      ctrlReg <= 8'h01;
      oeReg   <= 1'b0;
      loopSh  <= '0;
      fbLoSh  <= '0;
      fbHiSh  <= '0;
      trigSh  <= 1'b1;
      loopAct <= '0;
      fbAct   <= '0;
      trigAct <= 1'b1;
    end else begin
      if (strb.wrEn) begin
        case (ptr)
          A_INCTRL: ctrlReg <= strb.data & 8'h5F;
          A_LOOP:   loopSh  <= strb.data & 8'h37;
          A_FBLO:   fbLoSh  <= strb.data;
          A_FBHI:   fbHiSh  <= strb.data[3:0];
          A_TRIG:   trigSh  <= strb.data[0];
          A_OUTEN:  oeReg   <= strb.data[1];
          default: ;
        endcase
      end
      if (commitNow) begin
        loopAct <= loopSh;
        fbAct   <= {fbHiSh, fbLoSh};
        trigAct <= trigSh;
      end
      if (strb.loadPtr)
        ptr <= strb.data;
      else if (strb.wrEn || strb.incPtr)
        ptr <= {ptr[7:PAGE_BITS], ptr[PAGE_BITS-1:0] + PAGE_ONE};
    end
  end

  always_comb begin
    case (ptr)
      A_INCTRL: rdData = ctrlReg;
      A_LOOP:   rdData = loopSh;
      A_FBLO:   rdData = fbLoSh;
      A_FBHI:   rdData = {4'b0, fbHiSh};
      A_TRIG:   rdData = {7'b0, trigSh};
      A_OUTEN:  rdData = {6'b0, oeReg, 1'b0};
      A_REV:    rdData = REV_CODE;
      A_STAT:   rdData = {6'b0, lockPipe[1], 1'b0};
      default:  rdData = 8'h00;
    endcase
  end

  always_comb begin
    cfg.cpAlways      = ctrlReg[0];
    cfg.coastPol      = ctrlReg[1];
    cfg.hsyncFall     = ctrlReg[2];
    cfg.fbkFall       = ctrlReg[3];
    cfg.fbkExt        = ctrlReg[4];
    cfg.lockPinEn     = ctrlReg[6];
    cfg.pumpCur       = loopAct[2:0];
    cfg.vcoDiv        = loopAct[5:4];
    cfg.fbDiv         = fbAct;
    cfg.schmittBypass = trigAct;
    cfg.outEnable     = oeReg;
  end

  // R4: a write that is not a commit leaves the live loop settings alone
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && ptr != A_COMMIT) |=>
      ($stable(cfg.fbDiv) && $stable(cfg.pumpCur) && $stable(cfg.schmittBypass)));

  // R5: a commit copies the shadow contents exactly
  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    commitNow |=> (cfg.fbDiv == $past({fbHiSh, fbLoSh}) &&
                   cfg.vcoDiv == $past(loopSh[5:4]) &&
                   cfg.schmittBypass == $past(trigSh)));

  // R8: advancing the word address never leaves its page
  p_page_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incPtr && !strb.loadPtr) |=> ptr[7:PAGE_BITS] == $past(ptr[7:PAGE_BITS]));
endmodule

// File: rtl/clksyn_cfg_slave.sv
module clksyn_cfg_slave
  import clksyn_cfg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         PAGE_BITS   = 4,
  parameter logic [5:0] DEV_PREFIX  = 6'b010011,
  parameter logic [7:0] COMMIT_CODE = 8'h5A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaOe,
  input  logic        addrSel,
  input  logic        pllLocked,
  output logic        cpAlways,
  output logic        coastPol,
  output logic        hsyncFall,
  output logic        fbkFall,
  output logic        fbkExt,
  output logic        lockPinEn,
  output logic [2:0]  pumpCur,
  output logic [1:0]  vcoDiv,
  output logic [11:0] fbDiv,
  output logic        schmittBypass,
  output logic        outEnable
);
  busStrobe_t strb;
  cfgOut_t    cfg;
  logic [7:0] rdData;

  clksyn_cfg_ctl #(.SYNC_STAGES(SYNC_STAGES), .DEV_PREFIX(DEV_PREFIX)) uCtl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rdData(rdData), .strb(strb), .sdaOe(sdaOe)
  );

  clksyn_cfg_regs #(.PAGE_BITS(PAGE_BITS), .COMMIT_CODE(COMMIT_CODE)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .pllLocked(pllLocked),
    .rdData(rdData), .cfg(cfg)
  );

  assign cpAlways      = cfg.cpAlways;
  assign coastPol      = cfg.coastPol;
  assign hsyncFall     = cfg.hsyncFall;
  assign fbkFall       = cfg.fbkFall;
  assign fbkExt        = cfg.fbkExt;
  assign lockPinEn     = cfg.lockPinEn;
  assign pumpCur       = cfg.pumpCur;
  assign vcoDiv        = cfg.vcoDiv;
  assign fbDiv         = cfg.fbDiv;
  assign schmittBypass = cfg.schmittBypass;
  assign outEnable     = cfg.outEnable;
endmodule

// File: tb/sim_clksyn_cfg_slave.sv
`timescale 1ns/1ps
module sim_clksyn_cfg_slave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1, sdaM = 1'b1, addrSel = 1'b0, pllLocked = 1'b0;
  logic sdaOe, cpAlways, coastPol, hsyncFall, fbkFall, fbkExt, lockPinEn;
  logic schmittBypass, outEnable;
  logic [2:0] pumpCur;
  logic [1:0] vcoDiv;
  logic [11:0] fbDiv;
  wire sdaLine = sdaM & ~sdaOe;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic allAck;
  localparam time TQ = 50ns;

  always #2.5 clk = ~clk;

  clksyn_cfg_slave u0 (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .pllLocked(pllLocked), .cpAlways(cpAlways),
    .coastPol(coastPol), .hsyncFall(hsyncFall), .fbkFall(fbkFall),
    .fbkExt(fbkExt), .lockPinEn(lockPinEn), .pumpCur(pumpCur),
    .vcoDiv(vcoDiv), .fbDiv(fbDiv), .schmittBypass(schmittBypass),
    .outEnable(outEnable)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1; #TQ; scl = 1; #TQ; sdaM = 0; #TQ; scl = 0; #TQ;
  endtask

  task automatic busStop();
    sdaM = 0; #TQ; scl = 1; #TQ; sdaM = 1; #TQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; #TQ; scl = 1; #(2*TQ); scl = 0; #TQ;
    end
    sdaM = 1; #TQ; scl = 1; #TQ; ack = ~sdaLine; #TQ; scl = 0; #TQ;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaM = 1;
    for (int i = 7; i >= 0; i--) begin
      #TQ; scl = 1; #TQ; b[i] = sdaLine; #TQ; scl = 0; #TQ;
    end
    sdaM = ~ackIt; #TQ; scl = 1; #(2*TQ); scl = 0; #TQ; sdaM = 1;
  endtask

  function automatic logic [7:0] devByte(input logic rd);
    return {6'b010011, addrSel, rd};
  endfunction

  task automatic writeSeq(input logic [7:0] addr, input int n);
    logic a;
    allAck = 1;
    busStart();
    sendByte(devByte(0), a); allAck &= a;
    sendByte(addr, a); allAck &= a;
    for (int i = 0; i < n; i++) begin sendByte(wbuf[i], a); allAck &= a; end
    busStop();
    #(4*TQ);
  endtask

  task automatic readSeq(input logic [7:0] addr, input int n);
    logic a;
    allAck = 1;
    busStart();
    sendByte(devByte(0), a); allAck &= a;
    sendByte(addr, a); allAck &= a;
    busStart();  // repeated START (R11)
    sendByte(devByte(1), a); allAck &= a;
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rbuf[i]);
    busStop();
    #(4*TQ);
  endtask

  task automatic tReset();
    chk("R2 cpAlways", 16'(cpAlways), 16'h1);
    chk("R2 ctrl bits", 16'({coastPol, hsyncFall, fbkFall, fbkExt, lockPinEn}), 16'h0);
    chk("R2 schmittBypass", 16'(schmittBypass), 16'h1);
    chk("R2 outEnable", 16'(outEnable), 16'h0);
    chk("R2 loop", 16'({pumpCur, vcoDiv, fbDiv}), 16'h0);
    chk("R2 sdaOe", 16'(sdaOe), 16'h0);
  endtask

  task automatic tAddress();
    logic a;
    busStart(); sendByte(8'h4E, a); busStop(); #(4*TQ);
    chk("R1 foreign address NACK", 16'(a), 16'h0);
    busStart(); sendByte(8'h4C, a); busStop(); #(4*TQ);
    chk("R1 own address ACK sel0", 16'(a), 16'h1);
    addrSel = 1;
    busStart(); sendByte(8'h4C, a); busStop(); #(4*TQ);
    chk("R1 old address NACK sel1", 16'(a), 16'h0);
    busStart(); sendByte(8'h4E, a); busStop(); #(4*TQ);
    chk("R1 own address ACK sel1", 16'(a), 16'h1);
  endtask

  task automatic tImmediate();
    wbuf[0] = 8'hFE; writeSeq(8'h00, 1);
    chk("R3 ctrl fields", 16'({lockPinEn, fbkExt, fbkFall, hsyncFall, coastPol, cpAlways}), 16'h3E);
    readSeq(8'h00, 1);
    chk("R3 ctrl readback masked", 16'(rbuf[0]), 16'h5E);
    wbuf[0] = 8'hFF; writeSeq(8'h06, 1);
    chk("R3 outEnable set", 16'(outEnable), 16'h1);
    readSeq(8'h06, 1);
    chk("R3 06h readback masked", 16'(rbuf[0]), 16'h02);
  endtask

  task automatic tShadow();
    wbuf[0] = 8'hFF; wbuf[1] = 8'hAB; wbuf[2] = 8'hFC; writeSeq(8'h01, 3);
    wbuf[0] = 8'h00; writeSeq(8'h05, 1);
    chk("R4 fbDiv held", 16'(fbDiv), 16'h000);
    chk("R4 loop held", 16'({pumpCur, vcoDiv}), 16'h0);
    chk("R4 schmitt held", 16'(schmittBypass), 16'h1);
    readSeq(8'h01, 3);
    chk("R6 01h shadow", 16'(rbuf[0]), 16'h37);
    chk("R6 02h shadow", 16'(rbuf[1]), 16'hAB);
    chk("R6 03h shadow", 16'(rbuf[2]), 16'h0C);
    wbuf[0] = 8'h55; writeSeq(8'h08, 1);
    chk("R5 wrong code no commit", 16'(fbDiv), 16'h000);
    wbuf[0] = 8'h5A; writeSeq(8'h08, 1);
    chk("R7 fbDiv committed", 16'(fbDiv), 16'hCAB);
    chk("R5 pumpCur", 16'(pumpCur), 16'h7);
    chk("R5 vcoDiv", 16'(vcoDiv), 16'h3);
    chk("R5 schmitt committed", 16'(schmittBypass), 16'h0);
    wbuf[0] = 8'h12; writeSeq(8'h02, 1);
    readSeq(8'h02, 1);
    chk("R6 shadow differs from active", 16'(rbuf[0]), 16'h12);
    chk("R6 active unchanged", 16'(fbDiv), 16'hCAB);
  endtask

  task automatic tStatus();
    pllLocked = 1; #(4*TQ);
    readSeq(8'h10, 3);
    chk("R10 10h reads zero", 16'(rbuf[0]), 16'h00);
    chk("R9 revision", 16'(rbuf[1]), 16'h01);
    chk("R9 locked", 16'(rbuf[2]), 16'h02);
    pllLocked = 0; #(4*TQ);
    readSeq(8'h12, 1);
    chk("R9 unlocked", 16'(rbuf[0]), 16'h00);
    readSeq(8'h08, 1);
    chk("R10 08h reads zero", 16'(rbuf[0]), 16'h00);
  endtask

  task automatic tReserved();
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; writeSeq(8'h1A, 2);
    chk("R10 reserved bytes ACKed", 16'(allAck), 16'h1);
    wbuf[0] = 8'hC3; writeSeq(8'h07, 1);
    chk("R10 reserved write ACKed", 16'(allAck), 16'h1);
    readSeq(8'h07, 1);
    chk("R10 07h still zero", 16'(rbuf[0]), 16'h00);
    chk("R10 outputs unchanged", 16'({outEnable, schmittBypass, fbDiv}), 16'h2CAB);
  endtask

  task automatic tWrap();
    wbuf[0] = 8'h77; wbuf[1] = 8'h01; writeSeq(8'h0F, 2);
    chk("R8 write wraps to 00h", 16'({coastPol, hsyncFall, cpAlways}), 16'h1);
    readSeq(8'h0F, 3);
    chk("R8 read 0Fh", 16'(rbuf[0]), 16'h00);
    chk("R8 read wraps to 00h", 16'(rbuf[1]), 16'h01);
    chk("R8 then 01h", 16'(rbuf[2]), 16'h37);
    readSeq(8'h1F, 2);
    chk("R8 read 1Fh wraps to 10h", 16'(rbuf[1]), 16'h00);
    readSeq(8'h11, 1);
    chk("R12 bus usable after NACK end", 16'(rbuf[0]), 16'h01);
    chk("R12 SDA released at end", 16'(sdaOe), 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #20; rstN = 1; #100;
    tReset();
    tAddress();
    tImmediate();
    tShadow();
    tStatus();
    tReserved();
    tWrap();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule